// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a byte-addressed serial memory. A fast system clock samples the serial clock and data lines, which arrive already synchronized. The block finds START and STOP conditions and checks the first byte of each transfer against a fixed device code and three strap inputs. It then takes a two-byte word address and moves data between the bus and a byte-wide memory. Received bytes go to an external page buffer. A STOP that closes a write with data pulses a commit strobe, and an external write-cycle engine answers with a busy level.

The block answers none of the control bytes it sees while busy is high. A master can therefore poll for the end of a write cycle. The word address pointer is kept from one transaction to the next, so reads can continue where the previous access stopped. Random reads, current-address reads and sequential reads are all supported. The data line is driven only through an open-drain pull-low enable. Each new value on it appears a few system clocks after a falling serial clock edge.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after a START is a control byte: bits [7:4] must be 1010, bits [3:1] must equal `sel_i`, and bit 0 selects read (1) or write (0). The block acknowledges it only when both fields match.
- R2: After a control byte that does not match, the block keeps SDA released and issues no page-buffer writes until the next START.
- R3: While `busy_i` is high, no control byte is acknowledged.
- R4: In a write header, the high address byte comes first and then the low byte. Bit 7 of the high byte is ignored. Every byte the block receives is acknowledged by holding SDA low for the whole high phase of the ninth clock.
- R5: Each write data byte is strobed out once on `wr_en_o` with its address and value. Within a write, only the low 6 pointer bits advance, so more than 64 bytes wrap inside the page and overwrite earlier bytes.
- R6: A STOP that follows at least one complete data byte pulses `commit_o` for one cycle. A STOP during the address phase does not, and neither does a repeated START.
- R7: The pointer is kept across transactions. A read that begins without an address returns the byte at the last accessed address plus one.
- R8: A write header followed by a repeated START and a read control byte returns the byte at the address just given.
- R9: In a read, each master acknowledge sends the next byte, and the pointer wraps from 7FFF to 0000. A master not-acknowledge releases SDA and the block waits for a START.
- R10: Read data is sent MSB first. `sda_oe_o` changes only `HOLD_CYC` system clocks after a falling SCL edge, and never while SCL stays high.
- R11: After reset, and whenever the block is idle, `sda_oe_o` is low. The block never drives SDA high.
- R12: A START or a STOP in the middle of a byte abandons that byte. After a START, reception restarts with a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_i | input | 3 | Strapped device select value |
| busy_i | input | 1 | Write cycle in progress |
| rd_addr_o | output | ADDR_W | Current pointer, read address |
| rd_data_i | input | 8 | Byte stored at `rd_addr_o` |
| wr_en_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | ADDR_W | Address of the strobed byte |
| wr_data_o | output | 8 | Value of the strobed byte |
| commit_o | output | 1 | One-cycle pulse that starts a write cycle |

## Verification
Some properties are checked on every cycle. SDA is released whenever the engine is idle. The output enable holds still while SCL is high. A control byte that completes while busy is high always sends the engine idle. A START always resets reception to a fresh control byte. The pointer keeps its upper bits during page increments and wraps cleanly during reads. Other behaviour can only be shown through the bench's bus scenarios. These include data written and later read back at the right addresses, page rollover that overwrites, the absence of a commit after an aborted or redirected write, and ignored traffic after a non-matching control byte.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_SACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } phase_e;

    function automatic logic ctrl_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_CODE) && (b[3:1] == sel);
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_CTRL: return PH_AHI;
            PH_AHI:  return PH_ALO;
            default: return PH_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_ev = scl & scl_q & sda_q & ~sda;
    assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
    parameter int AW = 15,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_lin,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (inc_page)
            ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
        else if (inc_lin)
            ptr <= ptr + 1'b1;
    end

    // R5: a page increment keeps the page bits and steps only the offset
    assert_page_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load) |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW])) &&
                                (ptr[PW-1:0] == $past(ptr[PW-1:0]) + 1'b1));

    // R9: a read step from the top address lands on zero
    assert_read_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (inc_lin && !load && !inc_page && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/i2c_sda_drive.sv
module i2c_sda_drive #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic scl_fall,
    input  logic want_low,
    input  logic release_now,
    output logic sda_oe
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
        end else if (release_now) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
        end else if (scl_fall) begin
            cnt <= CW'(HOLD_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1))
                sda_oe <= want_low;
        end
    end

    // R10: the enable never moves during a high SCL phase
    assert_scl_high_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (scl && $past(scl) && !$past(release_now)) |-> $stable(sda_oe));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int PAGE_W   = 6,
    parameter int HOLD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        sel_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              commit_o
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_rise, scl_fall, start_ev, stop_ev;
    bus_st_e st;
    phase_e  ph;
    logic [2:0]      bitcnt;
    logic            byte_full;
    logic [7:0]      shreg;
    logic            rw;
    logic            mack;
    logic            wr_pending;
    logic [HI_W-1:0] hi_q;
    logic [ADDR_W-1:0] ptr;

    i2c_bus_events u_events (
        .clk(clk), .rst(rst), .scl(scl_i), .sda(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    logic byte_end, ctrl_ok, ptr_load, ptr_inc_pg, ptr_inc_lin, want_low;

    always_comb begin
        byte_end    = (st == ST_RX) && scl_fall && byte_full && !start_ev && !stop_ev;
        ctrl_ok     = ctrl_match(shreg, sel_i) && !busy_i;
        ptr_load    = byte_end && (ph == PH_ALO);
        ptr_inc_pg  = byte_end && (ph == PH_DATA);
        ptr_inc_lin = (st == ST_MACK) && scl_rise;
        want_low    = (st == ST_SACK) || ((st == ST_TX) && !shreg[7]);
    end

    i2c_addr_ptr #(.AW(ADDR_W), .PW(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst),
        .load(ptr_load), .load_val({hi_q, shreg}),
        .inc_page(ptr_inc_pg), .inc_lin(ptr_inc_lin),
        .ptr(ptr)
    );

    i2c_sda_drive #(.HOLD_CYC(HOLD_CYC)) u_drive (
        .clk(clk), .rst(rst), .scl(scl_i), .scl_fall(scl_fall),
        .want_low(want_low), .release_now(start_ev | stop_ev),
        .sda_oe(sda_oe_o)
    );

    assign rd_addr_o = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= PH_CTRL;
            bitcnt     <= '0;
            byte_full  <= 1'b0;
            shreg      <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            wr_pending <= 1'b0;
            hi_q       <= '0;
            wr_en_o    <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
            commit_o   <= 1'b0;
        end else begin
            wr_en_o  <= 1'b0;
            commit_o <= 1'b0;
            if (start_ev) begin
                st         <= ST_RX;
                ph         <= PH_CTRL;
                bitcnt     <= '0;
                byte_full  <= 1'b0;
                wr_pending <= 1'b0;
            end else if (stop_ev) begin
                // the stop sequence clocks at most one stray bit of a new byte
                commit_o   <= wr_pending && (st == ST_RX) && (ph == PH_DATA) &&
                              !byte_full && (bitcnt <= 3'd1);
                st         <= ST_IDLE;
                wr_pending <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_i};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7)
                                byte_full <= 1'b1;
                        end else if (byte_end) begin
                            byte_full <= 1'b0;
                            bitcnt    <= '0;
                            st        <= ST_SACK;
                            case (ph)
                                PH_CTRL: begin
                                    rw <= shreg[0];
                                    if (!ctrl_ok)
                                        st <= ST_IDLE;
                                end
                                PH_AHI: hi_q <= shreg[HI_W-1:0];
                                PH_DATA: begin
                                    wr_en_o    <= 1'b1;
                                    wr_addr_o  <= ptr;
                                    wr_data_o  <= shreg;
                                    wr_pending <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if ((ph == PH_CTRL) && rw) begin
                                st    <= ST_TX;
                                shreg <= rd_data_i;
                            end else begin
                                st <= ST_RX;
                                ph <= next_phase(ph);
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7)
                                st <= ST_MACK;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= !sda_i;
                        end else if (scl_fall) begin
                            if (mack) begin
                                st     <= ST_TX;
                                shreg  <= rd_data_i;
                                bitcnt <= '0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: an idle engine never holds the line
    assert_idle_released_R11: assert property (@(posedge clk) disable iff (rst)
        sda_oe_o |-> (st != ST_IDLE));

    // R3: a control byte that completes during a write cycle is dropped
    assert_busy_nack_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_end && (ph == PH_CTRL) && busy_i) |=> (st == ST_IDLE));

    // R12: a START always restarts control byte reception
    assert_start_restart_R12: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> ((st == ST_RX) && (ph == PH_CTRL) && (bitcnt == 3'd0) && !byte_full));

    // R6: a commit never coincides with the strobe of a new data byte
    assert_commit_alone_R6: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (!wr_en_o && $past(stop_ev)));
endmodule

// File: tb/i2c_mem_slave_tb.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb;
    localparam int AW     = 15;
    localparam int HALF   = 10;
    localparam int BUSY_N = 600;
    localparam int MASK   = 32767;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic busy;
    logic [7:0] rd_data = 8'h00;
    logic sda_oe, wr_en, commit;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    wire sda_line = sda_m & ~sda_oe;

    i2c_mem_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .sel_i(sel), .busy_i(busy),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit)
    );

    logic [7:0] phys [int];
    logic [7:0] stage [int];
    logic [7:0] refm [int];
    logic [7:0] wbuf [0:127];
    int busy_cnt = 0, n_wr = 0, n_commit = 0, hold_viol = 0;
    int errs = 0, checks = 0, exp_ptr = 0;
    logic scl_prev = 1'b1, oe_prev = 1'b0, done = 1'b0;

    function automatic logic [7:0] seed_val(int a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h3C;
    endfunction
    function automatic logic [7:0] phys_rd(int a);
        return phys.exists(a) ? phys[a] : seed_val(a);
    endfunction
    function automatic logic [7:0] ref_rd(int a);
        return refm.exists(a) ? refm[a] : seed_val(a);
    endfunction
    function automatic logic [7:0] ctrl(logic rw);
        return {4'b1010, sel, rw};
    endfunction

    assign busy = (busy_cnt != 0);

    // memory, page buffer and write-cycle model, updated away from the active edge
    always @(negedge clk) begin
        if (wr_en) begin
            stage[int'(wr_addr)] = wr_data;
            n_wr++;
        end
        if (commit) begin
            foreach (stage[k]) phys[k] = stage[k];
            stage.delete();
            n_commit++;
            busy_cnt = BUSY_N;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        rd_data = phys_rd(int'(rd_addr));
        if (scl_m && scl_prev && (sda_oe != oe_prev)) hold_viol++;
        scl_prev = scl_m;
        oe_prev  = sda_oe;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        tick(4); sda_m = b; tick(HALF - 4);
        scl_m = 1'b1; tick(HALF); scl_m = 1'b0;
    endtask

    // OR of three samples: a low result means low across the whole high phase
    task automatic bit_in(output logic b);
        logic s0, s1, s2;
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(1); s0 = sda_line;
        tick(HALF/2); s1 = sda_line;
        tick(HALF/2 - 2); s2 = sda_line;
        tick(1); scl_m = 1'b0;
        b = s0 | s1 | s2;
    endtask

    task automatic send_byte(logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(x);
        ack = !x;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!give_ack);
    endtask

    task automatic start_c();
        stage.delete();
        if (!scl_m) begin
            sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
        end else tick(5);
        sda_m = 1'b0; tick(5); scl_m = 1'b0;
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
    endtask

    task automatic send_hdr(int a, string req);
        logic ack;
        logic [14:0] aa;
        aa = a[14:0];
        send_byte(ctrl(1'b0), ack);                         chk({req, " R1 write control ack"}, ack, 1);
        send_byte({1'($urandom_range(0, 1)), aa[14:8]}, ack); chk("R4 high address ack", ack, 1);
        send_byte(aa[7:0], ack);                            chk("R4 low address ack", ack, 1);
    endtask

    task automatic poll_idle();
        logic ack;
        for (int p = 0; p < 100; p++) begin
            start_c();
            send_byte(ctrl(1'b0), ack);
            if (p == 0) chk("R3 no ack while busy", ack, 0);
            if (ack) begin
                stop_c();
                return;
            end
        end
        chk("R3 busy never ended", 0, 1);
    endtask

    task automatic do_write(int a, int n);
        logic ack;
        int c0, base;
        c0 = n_commit;
        base = a & 32'h7FC0;
        start_c();
        send_hdr(a, "write");
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk("R5 data byte ack", ack, 1);
            refm[base | ((a + i) & 63)] = wbuf[i];
        end
        stop_c();
        tick(2);
        chk("R6 commit after data STOP", n_commit - c0, 1);
        exp_ptr = base | ((a + n) & 63);
        poll_idle();
    endtask

    task automatic do_rand_read(int a, int n);
        logic ack;
        logic [7:0] v;
        start_c();
        send_hdr(a, "R8");
        start_c();
        send_byte(ctrl(1'b1), ack);
        chk("R8 read control ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i < n - 1);
            if (i == 0) chk("R8 random read data MSB first R10", v, ref_rd(a & MASK));
            else        chk("R9 sequential read data", v, ref_rd((a + i) & MASK));
        end
        stop_c();
        exp_ptr = (a + n) & MASK;
    endtask

    task automatic do_cur_read(int n);
        logic ack;
        logic [7:0] v;
        start_c();
        send_byte(ctrl(1'b1), ack);
        chk("R7 current read control ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i < n - 1);
            chk("R7 current address data", v, ref_rd((exp_ptr + i) & MASK));
        end
        stop_c();
        chk("R9 SDA released after master nack", sda_oe, 0);
        exp_ptr = (exp_ptr + n) & MASK;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        int w0, c0, op, a, n;
        void'($urandom(32'h1d2c));

        tick(10);
        chk("R11 reset oe", sda_oe, 0);
        chk("R11 reset wr_en", wr_en, 0);
        chk("R11 reset commit", commit, 0);
        rst = 1'b0;
        tick(20);
        chk("R11 idle oe", sda_oe, 0);

        // byte write, pointer continues, read back
        wbuf[0] = 8'hA5;
        do_write(32'h0040, 1);
        do_cur_read(1);
        do_rand_read(32'h0040, 1);

        // page write past 64 bytes wraps within the page
        for (int i = 0; i < 70; i++) wbuf[i] = 8'($urandom);
        do_write(32'h1234, 70);
        do_rand_read(32'h1200, 64);

        // sequential read across the top of the array
        do_rand_read(32'h7FFD, 5);
        do_cur_read(2);

        // non-matching select: everything ignored
        w0 = n_wr; c0 = n_commit;
        start_c();
        send_byte({4'b1010, sel ^ 3'b010, 1'b0}, ack);
        chk("R1 wrong select nack", ack, 0);
        send_byte(8'h00, ack); chk("R2 ignored byte nack", ack, 0);
        send_byte(8'h10, ack); chk("R2 ignored byte nack", ack, 0);
        send_byte(8'hEE, ack); chk("R2 ignored byte nack", ack, 0);
        stop_c();
        tick(2);
        chk("R2 no page buffer write", n_wr - w0, 0);
        chk("R2 no commit", n_commit - c0, 0);
        do_rand_read(32'h0010, 1);

        // wrong device code
        start_c();
        send_byte({4'b1011, sel, 1'b0}, ack);
        chk("R1 wrong code nack", ack, 0);
        stop_c();

        // STOP during address phase: no write, pointer untouched
        c0 = n_commit;
        start_c();
        send_byte(ctrl(1'b0), ack); chk("R1 control ack", ack, 1);
        send_byte(8'h03, ack);      chk("R4 high address ack", ack, 1);
        stop_c();
        tick(2);
        chk("R6 no commit after partial address", n_commit - c0, 0);
        chk("R6 not busy after partial address", busy, 0);
        do_cur_read(1);

        // data byte then repeated START: no write cycle
        c0 = n_commit;
        start_c();
        send_hdr(32'h0300, "R6");
        send_byte(8'h77, ack); chk("R5 data ack", ack, 1);
        start_c();
        send_byte(ctrl(1'b1), ack); chk("R12 read control after repeated START", ack, 1);
        recv_byte(v, 1'b0);
        chk("R12 read continues at next address", v, ref_rd(32'h0301));
        stop_c();
        tick(2);
        chk("R6 no commit after repeated START", n_commit - c0, 0);
        do_rand_read(32'h0300, 1);

        // STOP in the middle of a data byte: abandoned, no commit
        c0 = n_commit;
        start_c();
        send_hdr(32'h0500, "R12");
        send_byte(8'h99, ack); chk("R5 data ack", ack, 1);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        stop_c();
        tick(2);
        chk("R12 no commit after mid-byte STOP", n_commit - c0, 0);
        do_rand_read(32'h0500, 1);

        // START in the middle of a control byte restarts reception
        start_c();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
        do_cur_read(1);

        // constrained random mix
        for (int k = 0; k < 25; k++) begin
            op = $urandom_range(0, 2);
            a  = $urandom_range(0, MASK);
            n  = $urandom_range(1, 6);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            case (op)
                0: do_write(a, n);
                1: do_rand_read(a, n);
                default: do_cur_read(n);
            endcase
        end

        chk("R10 oe never changed while SCL high", hold_viol, 0);
        chk("R11 idle oe at end", sda_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule